// File: doc/BRIEF.md
# Paged Scan Access Controller

This block gives a test controller random access to a large array of single-cycle access register cells. The cells are grouped into pages. Each page holds a number of lines, and each line is as wide as the scan bus. One request names a page and a line, and it either writes the scan-in word into that line or reads the line back onto the global scan-out bus. No request shifts data through neighbouring cells.

The line address goes to a one-hot decoder that is shared by all pages. The page address is decoded into a page-select vector. Each bit of that vector gates the scan-in word and the line selects into its own page. A page that is not selected sees all-zero line selects, so it keeps its contents and drives zeros on its scan-out bus. The scan-out buses of all pages are merged bitwise by an XOR tree. Because every page other than the selected one is silent, the tree delivers the selected line unchanged.

Two optional pipeline stages are available. `IN_REG` registers the decoded selects, the access type and the scan-in word. `OUT_REG` registers the output of the tree. The read latency `LAT` equals `IN_REG + OUT_REG`. The register cells are modelled behaviourally.

Top module: `paged_scan_access`

## Requirements
- R1: After reset every cell holds zero and `scan_out` is zero; a read of any in-range address returns zero.
- R2: A write (`acc_en`=1, `acc_wr`=1) to an in-range page and line stores `scan_in` in that line only; every other line on every page keeps its value.
- R3: A read (`acc_en`=1, `acc_wr`=0) of an in-range address places the stored word on `scan_out`. The word appears after `LAT` rising edges, where the first of these edges is the one that samples the request. With `LAT`=0 it appears in the same cycle.
- R4: For a cycle in which no read is requested (strobe low, or a write), `scan_out` is zero `LAT` edges later. This holds because every unselected page drives zeros into the XOR merge.
- R5: A line address of `SD` or above selects no line. A write to it changes no cell, and a read of it returns zero.
- R6: A page address of `NPAGES` or above selects no page. A write to it changes no cell, and a read of it returns zero.
- R7: A read issued in the cycle right after a write to the same address returns the newly written word.
- R8: Reads issued on consecutive cycles to different addresses return one result per cycle, in request order, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one request per cycle while high |
| acc_wr | input | 1 | 1 = write, 0 = read |
| page_addr | input | PW | Page address |
| line_addr | input | LW | Line address within the page |
| scan_in | input | SW | Word to write |
| scan_out | output | SW | Merged read data from all pages |

## Verification
A write can commit to the cell array in the same clock edge at which a read of the same line is being staged. This is provoked by issuing a write immediately followed by a read of that address. The read is judged against a bench shadow memory that applies the write first. The output path also sees a read result and the zero of a neighbouring write or idle slot in adjacent cycles. Random streams that mix reads, writes, idle cycles and out-of-range addresses check every output slot against its own expected word, so one slot leaking into the next is caught.

// File: rtl/paged_scan_access.sv
module paged_scan_access #(
  parameter int NPAGES  = 5,
  parameter int SD      = 6,
  parameter int SW      = 16,
  parameter int IN_REG  = 1,
  parameter int OUT_REG = 1,
  localparam int PW  = (NPAGES > 1) ? $clog2(NPAGES) : 1,
  localparam int LW  = (SD > 1) ? $clog2(SD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic [PW-1:0] page_addr,
  input  logic [LW-1:0] line_addr,
  input  logic [SW-1:0] scan_in,
  output logic [SW-1:0] scan_out
);
  localparam int LEV = (NPAGES > 1) ? $clog2(NPAGES) : 1;
  localparam int N2  = 1 << LEV;

  logic [SD-1:0]     ls_d, ls_s;
  logic [NPAGES-1:0] ps_d, ps_s;
  logic              wr_s;
  logic [SW-1:0]     si_s;

  always_comb begin
    ls_d = '0;
    ps_d = '0;
    for (int l = 0; l < SD; l++)
      if (acc_en && 32'(line_addr) == l) ls_d[l] = 1'b1;
    for (int p = 0; p < NPAGES; p++)
      if (acc_en && 32'(page_addr) == p) ps_d[p] = 1'b1;
  end

  generate
    if (IN_REG != 0) begin : g_in_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ls_s <= '0;
          ps_s <= '0;
          wr_s <= 1'b0;
          si_s <= '0;
        end else begin
          ls_s <= ls_d;
          ps_s <= ps_d;
          wr_s <= acc_wr;
          si_s <= scan_in;
        end
    end else begin : g_in_comb
      assign ls_s = ls_d;
      assign ps_s = ps_d;
      assign wr_s = acc_wr;
      assign si_s = scan_in;
    end
  endgenerate

  logic [NPAGES-1:0][SD-1:0] pg_ls;
  logic [NPAGES-1:0][SW-1:0] pg_si, page_so;
  logic [NPAGES-1:0]         pg_rd;
  logic [NPAGES*SD-1:0][SW-1:0] cells;

  always_comb begin
    for (int p = 0; p < NPAGES; p++) begin
      pg_ls[p]   = ls_s & {SD{ps_s[p]}};
      pg_si[p]   = si_s & {SW{ps_s[p]}};
      pg_rd[p]   = ps_s[p] & (|ls_s) & ~wr_s;
      page_so[p] = '0;
      for (int l = 0; l < SD; l++)
        if (pg_ls[p][l] && !wr_s) page_so[p] = page_so[p] | cells[p*SD+l];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cells <= '0;
    else
      for (int p = 0; p < NPAGES; p++)
        for (int l = 0; l < SD; l++)
          if (wr_s && pg_ls[p][l]) cells[p*SD+l] <= pg_si[p];

  logic [SW-1:0] node [1:2*N2-1];

  generate
    for (genvar i = 0; i < N2; i++) begin : g_leaf
      if (i < NPAGES) begin : g_pg
        assign node[N2+i] = page_so[i];
      end else begin : g_pad
        assign node[N2+i] = '0;
      end
    end
    for (genvar k = 1; k < N2; k++) begin : g_xor
      assign node[k] = node[2*k] ^ node[2*k+1];
    end
    if (OUT_REG != 0) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) scan_out <= '0;
        else        scan_out <= node[1];
    end else begin : g_out_comb
      assign scan_out = node[1];
    end
  endgenerate
endmodule

module paged_scan_access_chk #(
  parameter int NPAGES  = 5,
  parameter int SD      = 6,
  parameter int SW      = 16,
  parameter int OUT_REG = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_s,
  input logic [SD-1:0]               ls_s,
  input logic [NPAGES-1:0]           ps_s,
  input logic [SW-1:0]               si_s,
  input logic [NPAGES-1:0]           pg_rd,
  input logic [NPAGES*SD-1:0][SW-1:0] cells,
  input logic [SW-1:0]               scan_out
);
  a_r3_single_page: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pg_rd));

  generate
    if (OUT_REG != 0) begin : g_q
      a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pg_rd) |=> scan_out == '0);
    end else begin : g_c
      a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pg_rd) |-> scan_out == '0);
    end
    for (genvar gp = 0; gp < NPAGES; gp++) begin : g_p
      for (genvar gl = 0; gl < SD; gl++) begin : g_l
        localparam int IDX = gp*SD + gl;
        a_r2_write: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_s && ps_s[gp] && ls_s[gl]) |=> cells[IDX] == $past(si_s));
        a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
          !(wr_s && ps_s[gp] && ls_s[gl]) |=> $stable(cells[IDX]));
      end
    end
  endgenerate
endmodule

bind paged_scan_access paged_scan_access_chk #(
  .NPAGES(NPAGES), .SD(SD), .SW(SW), .OUT_REG(OUT_REG)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_s(wr_s), .ls_s(ls_s), .ps_s(ps_s),
  .si_s(si_s), .pg_rd(pg_rd), .cells(cells), .scan_out(scan_out)
);

// File: tb/test_paged_scan_access.sv
module test_paged_scan_access;
  localparam int CLK_PERIOD = 10;
  localparam int NPAGES = 5;
  localparam int SD = 6;
  localparam int SW = 16;
  localparam int IN_REG = 1;
  localparam int OUT_REG = 1;
  localparam int LAT = IN_REG + OUT_REG;
  localparam int PW = (NPAGES > 1) ? $clog2(NPAGES) : 1;
  localparam int LW = (SD > 1) ? $clog2(SD) : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0;
  logic [PW-1:0] page_addr = '0;
  logic [LW-1:0] line_addr = '0;
  logic [SW-1:0] scan_in = '0;
  logic [SW-1:0] scan_out;

  int checks = 0, errors = 0;
  logic [SW-1:0] shadow [NPAGES][SD];
  logic [SW-1:0] exq [$];
  string tq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_scan_access #(.NPAGES(NPAGES), .SD(SD), .SW(SW), .IN_REG(IN_REG),
    .OUT_REG(OUT_REG)) i_paged_scan_access (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .page_addr(page_addr), .line_addr(line_addr), .scan_in(scan_in),
    .scan_out(scan_out));

  function automatic logic [SW-1:0] expect_word(logic en, logic wr, int p, int l);
    if (en && !wr && p < NPAGES && l < SD) return shadow[p][l];
    return '0;
  endfunction

  task automatic chk(logic [SW-1:0] act, logic [SW-1:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: scan_out=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic en, logic wr, int p, int l, logic [SW-1:0] d, string rtag);
    string t;
    @(negedge clk);
    acc_en = en; acc_wr = wr;
    page_addr = PW'(p); line_addr = LW'(l); scan_in = d;
    exq.push_back(expect_word(en, wr, p, l));
    if (en && !wr) t = (p >= NPAGES) ? "R6" : (l >= SD) ? "R5" : rtag;
    else t = "R4";
    tq.push_back(t);
    if (en && wr && p < NPAGES && l < SD) shadow[p][l] = d;
    #1;
    if (exq.size() > LAT) chk(scan_out, exq.pop_front(), tq.pop_front());
  endtask

  task automatic sweep(string tag);
    for (int p = 0; p < NPAGES; p++)
      for (int l = 0; l < SD; l++) step(1, 0, p, l, '0, tag);
  endtask

  task automatic drain();
    for (int i = 0; i < LAT; i++) step(0, 0, 0, 0, '0, "R4");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5CA1_0042));
    for (int p = 0; p < NPAGES; p++)
      for (int l = 0; l < SD; l++) shadow[p][l] = '0;
    repeat (3) @(negedge clk);
    #1 chk(scan_out, '0, "R1");
    rst_n = 1'b1;
    sweep("R1");
    drain();

    // R2 R3: corners of the array
    step(1, 1, 0, 0, 16'hA5A5, "R2");
    step(1, 1, NPAGES-1, SD-1, 16'h3C0F, "R2");
    step(1, 0, 0, 0, '0, "R3");
    step(1, 0, NPAGES-1, SD-1, '0, "R3");
    step(0, 0, 0, 0, '0, "R4");

    // R7: write then read same address next cycle
    step(1, 1, 2, 3, 16'hBEEF, "R7");
    step(1, 0, 2, 3, '0, "R7");
    step(1, 1, 2, 3, 16'h1234, "R7");
    step(1, 0, 2, 3, '0, "R7");

    // R5 R6: out-of-range writes then reads
    step(1, 1, 1, SD, 16'hFFFF, "R5");
    step(1, 1, NPAGES, 2, 16'hFFFF, "R6");
    step(1, 0, 1, SD, '0, "R5");
    step(1, 0, NPAGES, 2, '0, "R6");
    sweep("R5");

    // R8: back-to-back reads of distinct data
    for (int l = 0; l < SD; l++) step(1, 1, 4, l, SW'(16'h0101 * (l + 1)), "R2");
    for (int l = 0; l < SD; l++) step(1, 0, 4, l, '0, "R8");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic en, wr;
      int p, l;
      en = ($urandom_range(0, 3) != 0);
      wr = $urandom_range(0, 1) == 1;
      p = $urandom_range(0, (1 << PW) - 1);
      l = $urandom_range(0, (1 << LW) - 1);
      step(en, wr, p, l, SW'($urandom), "R3");
    end

    sweep("R2");
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule